// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

This block is a small storage register that can hold its value, shift one place toward its top bit, shift one place toward its bottom bit, or capture a whole parallel word. A two-bit mode code picks the action, and an enable input decides whether any action happens on a given rising clock edge. Each shift direction has its own serial input, which feeds the bit position left empty by the shift. Each direction also has its own serial output, which shows the bit that such a shift would push out.

The parallel output always shows the stored word. Designs use the block as a serial-to-parallel or parallel-to-serial converter in either bit order, or as a holding register that takes a word in one cycle. A synchronous active-high reset clears the stored word and takes priority over the enable.

Top module: `shreg_bidir`

## Requirements
- R1: When `rst` is high at a rising edge, the stored word becomes all zeros on that edge, whatever `en`, `mode` and the data inputs are.
- R2: When `en` is low and `rst` is low at a rising edge, the stored word keeps its value for every `mode` code.
- R3: With `en` high, mode code 2'b00 keeps the stored word unchanged.
- R4: With `en` high, mode code 2'b01 moves every bit one place toward the top bit (bit i takes the old bit i-1), and bit 0 takes `shl_in`.
- R5: With `en` high, mode code 2'b10 moves every bit one place toward bit 0 (bit i takes the old bit i+1), and the top bit takes `shr_in`.
- R6: With `en` high, mode code 2'b11 copies `par_in` into the stored word.
- R7: `par_out` equals the stored word at all times. `shl_out` equals its top bit and `shr_out` equals its bit 0. Each serial output therefore shows the bit that the next shift in its direction drops.
- R8: After WIDTH shifts in one direction, the serial output for that direction has shown the original word, one bit per cycle, starting with the bit at the exit end. The stored word then equals the serial inputs that were fed in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable |
| mode | input | 2 | Action code: 00 hold, 01 shift toward top, 10 shift toward bit 0, 11 load |
| par_in | input | WIDTH | Parallel load data |
| shl_in | input | 1 | Serial input entering bit 0 on an upward shift |
| shr_in | input | 1 | Serial input entering the top bit on a downward shift |
| par_out | output | WIDTH | Stored word |
| shl_out | output | 1 | Top bit of the stored word |
| shr_out | output | 1 | Bit 0 of the stored word |

## Verification
The bench builds the block with its default WIDTH of 4. At that width all sixteen load values can be applied, and a full flush in each direction takes only four cycles. Both end bits, which take their value from a serial pin instead of a neighbour, are therefore reached in every shift test. Alternating and single-one patterns show whether bits cross over in the wrong direction.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } shreg_mode_e;
endpackage

// File: rtl/shreg_next.sv
`timescale 1ns/1ps
module shreg_next
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] par_in,
  input  logic             shl_in,
  input  logic             shr_in,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;

    if (i == 0) begin : g_low_end
      assign from_below = shl_in;
    end else begin : g_low_mid
      assign from_below = cur[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign from_above = shr_in;
    end else begin : g_high_mid
      assign from_above = cur[i+1];
    end

    always_comb begin
      unique case (shreg_mode_e'(mode))
        MODE_UP:   nxt[i] = from_below;
        MODE_DOWN: nxt[i] = from_above;
        MODE_LOAD: nxt[i] = par_in[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/shreg_store.sv
`timescale 1ns/1ps
module shreg_store #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R2
endmodule

// File: rtl/shreg_bidir.sv
`timescale 1ns/1ps
module shreg_bidir
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             shl_in,
  input  logic             shr_in,
  output logic [WIDTH-1:0] par_out,
  output logic             shl_out,
  output logic             shr_out
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .cur    (word_q),
    .par_in (par_in),
    .shl_in (shl_in),
    .shr_in (shr_in),
    .nxt    (word_d)
  );

  shreg_store #(.WIDTH(WIDTH)) u_store (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (word_d),
    .q   (word_q)
  );

  assign par_out = word_q;
  assign shl_out = word_q[TOP];
  assign shr_out = word_q[0];

  AST_KEEP_MODE: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_KEEP) |=> $stable(word_q)); // R3
  AST_UP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_UP) |=>
      (word_q == {$past(word_q[TOP-1:0]), $past(shl_in)})); // R4
  AST_DOWN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_DOWN) |=>
      (word_q == {$past(shr_in), $past(word_q[TOP:1])})); // R5
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_LOAD) |=> (word_q == $past(par_in))); // R6
endmodule

// File: tb/tb_shreg_bidir.sv
`timescale 1ns/1ps
module tb_shreg_bidir;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst, en, shl_in, shr_in;
  logic [1:0] mode;
  logic [W-1:0] par_in;
  logic [W-1:0] par_out;
  logic shl_out, shr_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  shreg_bidir #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .par_in(par_in),
    .shl_in(shl_in), .shr_in(shr_in), .par_out(par_out),
    .shl_out(shl_out), .shr_out(shr_out)
  );

  task automatic check_bit(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_word(string tag);
    n_chk++;
    if (par_out !== model) begin
      n_bad++;
      $display("FAIL %s: par_out got %b expected %b", tag, par_out, model);
    end
    check_bit({tag, " R7 shl_out"}, shl_out, model[W-1]);
    check_bit({tag, " R7 shr_out"}, shr_out, model[0]);
  endtask

  // one clock edge: drive at falling edge, sample 2 ns after the rising edge
  task automatic step(logic r, logic e, logic [1:0] m, logic [W-1:0] d,
                      logic li, logic ri);
    @(negedge clk);
    rst = r; en = e; mode = m; par_in = d; shl_in = li; shr_in = ri;
    if (r)           model = '0;
    else if (e) begin
      case (m)
        2'b01: model = {model[W-2:0], li};
        2'b10: model = {ri, model[W-1:1]};
        2'b11: model = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    step(1, 0, 2'b11, 4'hF, 1, 1);
    check_word("R1 reset en low");
    step(0, 1, 2'b11, 4'hA, 0, 0);
    step(1, 1, 2'b11, 4'h5, 1, 1);
    check_word("R1 reset beats load");
  endtask

  task automatic t_disabled;
    step(0, 1, 2'b11, 4'h9, 0, 0);
    for (int m = 0; m < 4; m++) begin
      step(0, 0, m[1:0], 4'h6, 1, 1);
      check_word("R2 enable low");
    end
  endtask

  task automatic t_keep;
    step(0, 1, 2'b11, 4'hC, 0, 0);
    step(0, 1, 2'b00, 4'h3, 1, 1);
    check_word("R3 keep mode");
  endtask

  task automatic t_load;
    for (int v = 0; v < 16; v++) begin
      step(0, 1, 2'b11, v[W-1:0], v[0], v[1]);
      check_word("R6 load");
    end
  endtask

  task automatic t_up;
    step(0, 1, 2'b11, 4'b0101, 0, 0);
    step(0, 1, 2'b01, 4'h0, 1, 0);
    check_word("R4 up shift alt");
    step(0, 1, 2'b11, 4'b0001, 0, 0);
    step(0, 1, 2'b01, 4'hF, 0, 1);
    check_word("R4 up shift single");
  endtask

  task automatic t_down;
    step(0, 1, 2'b11, 4'b1010, 0, 0);
    step(0, 1, 2'b10, 4'h0, 0, 1);
    check_word("R5 down shift alt");
    step(0, 1, 2'b11, 4'b1000, 0, 0);
    step(0, 1, 2'b10, 4'hF, 1, 0);
    check_word("R5 down shift single");
  endtask

  task automatic t_flush;
    logic [W-1:0] orig;
    orig = 4'b1101;
    step(0, 1, 2'b11, orig, 0, 0);
    for (int i = 0; i < W; i++) begin
      check_bit("R8 up flush serial", shl_out, orig[W-1-i]);
      step(0, 1, 2'b01, 4'h0, i[0], 0);
    end
    n_chk++;
    if (par_out !== 4'b0101) begin
      n_bad++;
      $display("FAIL R8 up flush word: got %b expected %b", par_out, 4'b0101);
    end
    orig = 4'b0110;
    step(0, 1, 2'b11, orig, 0, 0);
    for (int i = 0; i < W; i++) begin
      check_bit("R8 down flush serial", shr_out, orig[i]);
      step(0, 1, 2'b10, 4'h0, 0, ~i[0]);
    end
    n_chk++;
    if (par_out !== 4'b0101) begin
      n_bad++;
      $display("FAIL R8 down flush word: got %b expected %b", par_out, 4'b0101);
    end
  endtask

  initial begin
    rst = 1; en = 0; mode = 2'b00; par_in = '0; shl_in = 0; shr_in = 0;
    t_reset();
    t_disabled();
    t_keep();
    t_load();
    t_up();
    t_down();
    t_flush();
    t_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule